// File: doc/BRIEF.md
# System Handler Priority and Status Bank

This block is the register bank that sits beside an exception controller and serves the configurable system handlers: the three fault handlers (memory, bus, usage), the service call, the debug monitor, the deferred service request and the periodic tick. It keeps twelve 8-bit handler priorities in byte storage that a register port can reach with byte, halfword or word accesses. The priorities are also driven out in parallel to the arbitration logic.

A 32-bit handler status word merges live active and pending flags, which arrive from the exception logic, with three stored enable bits for the fault handlers. The enables are driven out to the exception logic. A key-guarded application control word rounds out the bank. It always reads back a fixed pattern, and a write that carries the correct 16-bit key and asks for a reset raises a one-cycle system reset request.

Accesses are single-cycle. A write is captured at the rising clock edge on which `acc_valid` and `acc_write` are high. Read data is combinational from the address and size that are presented while `acc_valid` is high and `acc_write` is low.

Top module: `shb_regbank`

## Requirements
- R1: After a synchronous active-low reset, all twelve priority bytes read as zero, `fault_en` is 3'b000 and `sys_reset_req` is low.
- R2: Priority bytes live at byte addresses 0xD18 to 0xD23. The size code (0 = byte, 1 = halfword, 2 = word) selects 1, 2 or 4 consecutive bytes starting at `acc_addr`. Lane i of `acc_wdata[8i+7:8i]` goes to address `acc_addr`+i. The byte at 0xD18+k also appears on `prio_bytes[8k+7:8k]`.
- R3: A read of the priority region returns the byte at address `acc_addr`+i on lane i. Lanes that fall outside the access size or outside 0xD18 to 0xD23 read zero, and writes to such lanes store nothing.
- R4: A word read at 0xD24 reports the active flags at these bits: bit 0 memory fault, bit 1 bus fault, bit 3 usage fault, bit 7 service call, bit 8 debug monitor, bit 10 deferred service and bit 11 tick. These come from `act_flags` indices 0 to 6 in that order.
- R5: The same word reports the pending flags at these bits: bit 12 usage fault, bit 13 memory fault, bit 14 bus fault and bit 15 service call. They come from `pend_flags` indices 0 to 3, which carry memory, bus, usage and service call in that order.
- R6: A word write at 0xD24 stores `acc_wdata[16]`, `[17]` and `[18]` as the memory, bus and usage fault enables. These bits read back at the same positions and drive `fault_en[0]`, `[1]` and `[2]`.
- R7: A write to the status word leaves the reported active and pending bits equal to the inputs. All status bits other than those named in R4 to R6 read zero.
- R8: A word read at 0xD0C always returns 0xFA050000.
- R9: A word write at 0xD0C is accepted only when `acc_wdata[31:16]` equals 0x05FA. Any other key leaves `sys_reset_req` low.
- R10: An accepted write at 0xD0C with `acc_wdata[2]` set drives `sys_reset_req` high for exactly one cycle, in the cycle after the write edge. It is never high in two consecutive cycles.
- R11: The status and application control words respond only to word-size accesses at their exact addresses. Narrower writes to them change nothing, and size code 3 is ignored everywhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe for the register port |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Byte address of the lowest byte accessed |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 no access |
| acc_wdata | input | 32 | Write data, lowest address on bits 7:0 |
| acc_rdata | output | 32 | Combinational read data |
| act_flags | input | 7 | Handler active flags from the exception logic |
| pend_flags | input | 4 | Fault and service call pending flags |
| fault_en | output | 3 | Stored memory, bus and usage fault enables |
| prio_bytes | output | 96 | All twelve priority bytes, byte k on bits 8k+7:8k |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The status word combines two sources that can change in the same cycle. The stored enables are updated by a register write, and the active and pending flags follow the exception logic. The bench changes both `act_flags`/`pend_flags` and issues an enable write on the same falling edge. The read that follows must show the new flags at the positions in R4 and R5 together with the newly written enables, and the flag bits of the written data must have no effect. Mixed-size priority writes that straddle the ends of the region are judged byte by byte against a model array in the bench.

// File: rtl/shb_pkg.sv
// Shared definitions for the system handler priority and status bank.
// Assumes a 32-bit register port that is split into four byte lanes.
package shb_pkg;

    localparam int LANES = 4;

    // Access size codes carried on acc_size.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_NONE = 2'd3
    } acc_size_e;

    // Key value expected in bits [31:16] of an application control write.
    localparam logic [15:0] APP_KEY  = 16'h05FA;
    // Fixed value returned by a read of the application control word.
    localparam logic [31:0] APP_READ = 32'hFA050000;

    // Number of bytes that an access of the given size touches.
    function automatic logic [2:0] size_to_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            SZ_WORD: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/shb_prio_store.sv
// Byte-addressable priority storage.
// Holds NBYTES bytes starting at byte address BASE. An access covers
// nbytes consecutive addresses from addr, one per lane, with lane 0 at
// the lowest address. Lanes that fall outside the region read zero and
// are not written. Assumes nbytes never exceeds LANES.
module shb_prio_store #(
    parameter int                ADDR_W = 12,
    parameter logic [ADDR_W-1:0] BASE   = 12'hD18,
    parameter int                NBYTES = 12,
    parameter int                LANES  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [2:0]            nbytes,
    input  logic [8*LANES-1:0]    wdata,
    output logic [8*LANES-1:0]    rdata,
    output logic [8*NBYTES-1:0]   prio_flat
);

    localparam int IW = ADDR_W + 1;

    logic [IW-1:0]     lane_idx [LANES];
    logic [NBYTES-1:0] byte_we;
    logic [7:0]        byte_wd  [NBYTES];
    logic [7:0]        store_q  [NBYTES];

    // Relative index of each lane; out-of-region lanes land far above NBYTES.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lane_idx[i] = ({1'b0, addr} + IW'(i)) - {1'b0, BASE};
        end
    end

    // Route the write lanes onto the stored bytes they cover.
    always_comb begin
        byte_we = '0;
        for (int k = 0; k < NBYTES; k++) begin
            byte_wd[k] = 8'h00;
        end
        for (int i = 0; i < LANES; i++) begin
            for (int k = 0; k < NBYTES; k++) begin
                if (wr_en && (int'(nbytes) > i) && (lane_idx[i] == IW'(k))) begin
                    byte_we[k] = 1'b1;
                    byte_wd[k] = wdata[8*i +: 8];
                end
            end
        end
    end

    // Gather the read lanes from the stored bytes.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < LANES; i++) begin
            for (int k = 0; k < NBYTES; k++) begin
                if ((int'(nbytes) > i) && (lane_idx[i] == IW'(k))) begin
                    rdata[8*i +: 8] = store_q[k];
                end
            end
        end
    end

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        // Hold one priority byte, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                store_q[k] <= 8'h00;
            end else if (byte_we[k]) begin
                store_q[k] <= byte_wd[k];
            end
        end

        assign prio_flat[8*k +: 8] = store_q[k];

        // R2: a byte that was not addressed by a write keeps its value.
        p_byte_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !byte_we[k] |=> $stable(prio_flat[8*k +: 8]))
            else $error("priority byte changed without a write");
    end

    // R3: a single write never covers more stored bytes than there are lanes.
    p_lane_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(byte_we) <= LANES)
        else $error("too many priority bytes written at once");

endmodule

// File: rtl/shb_status_word.sv
// Handler status word.
// Reports live active and pending flags at fixed positions, and stores
// three fault enables that a word write updates. Assumes wr_en is high
// only for a word write at the status address.
module shb_status_word (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  en_wdata,
    input  logic [6:0]  act_flags,
    input  logic [3:0]  pend_flags,
    output logic [2:0]  fault_en,
    output logic [31:0] rdata
);

    logic [2:0] en_q;

    // Store the memory, bus and usage fault enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 3'b000;
        end else if (wr_en) begin
            en_q <= en_wdata;
        end
    end

    assign fault_en = en_q;

    // Assemble the reported status word from the flags and the enables.
    always_comb begin
        rdata       = '0;
        rdata[0]    = act_flags[0];
        rdata[1]    = act_flags[1];
        rdata[3]    = act_flags[2];
        rdata[7]    = act_flags[3];
        rdata[8]    = act_flags[4];
        rdata[10]   = act_flags[5];
        rdata[11]   = act_flags[6];
        rdata[12]   = pend_flags[2];
        rdata[13]   = pend_flags[0];
        rdata[14]   = pend_flags[1];
        rdata[15]   = pend_flags[3];
        rdata[18:16] = en_q;
    end

    // R6: the enables change only on a status write.
    p_en_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(fault_en))
        else $error("fault enables changed without a write");

    // R6: after a status write the enables equal the written bits.
    p_en_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (fault_en == $past(en_wdata)))
        else $error("fault enables not loaded");

endmodule

// File: rtl/shb_app_ctrl.sv
// Key-guarded application control word.
// Always reads a fixed pattern. A write with the right key and the reset
// bit set raises a one-cycle reset request. Assumes wr_en is high only
// for a word write at the control address.
module shb_app_ctrl
    import shb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] key_in,
    input  logic        rst_bit,
    output logic [31:0] rdata,
    output logic        reset_req
);

    logic key_ok;
    logic req_q;

    assign key_ok = (key_in == APP_KEY);

    // Register the reset request; a request never lasts two cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= wr_en && key_ok && rst_bit && !req_q;
        end
    end

    assign reset_req = req_q;
    assign rdata     = APP_READ;

    // R10: the request is a single-cycle pulse.
    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req)
        else $error("reset request held longer than one cycle");

    // R9: a request follows only a keyed write with the reset bit.
    p_keyed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> $past(wr_en && (key_in == 16'h05FA) && rst_bit))
        else $error("reset request without keyed write");

endmodule

// File: rtl/shb_regbank.sv
// System handler priority and status bank, top level.
// Decodes a single-cycle register port onto the priority store, the status
// word and the application control word. Writes take effect at the clock
// edge; read data is combinational. Assumes the exception logic drives the
// active and pending flags synchronously to clk.
module shb_regbank
    import shb_pkg::*;
#(
    parameter int                ADDR_W      = 12,
    parameter int                NPRIO       = 12,
    parameter logic [ADDR_W-1:0] PRIO_BASE   = 12'hD18,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 12'hD24,
    parameter logic [ADDR_W-1:0] APP_ADDR    = 12'hD0C
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [1:0]           acc_size,
    input  logic [31:0]          acc_wdata,
    output logic [31:0]          acc_rdata,
    input  logic [6:0]           act_flags,
    input  logic [3:0]           pend_flags,
    output logic [2:0]           fault_en,
    output logic [8*NPRIO-1:0]   prio_bytes,
    output logic                 sys_reset_req
);

    localparam int DW = 8 * LANES;

    logic [2:0]    nbytes;
    logic          is_word;
    logic          hit_status;
    logic          hit_app;
    logic          wr_any;
    logic          rd_any;
    logic [DW-1:0] prio_rdata;
    logic [31:0]   status_rdata;
    logic [31:0]   app_rdata;

    // Decode access size and the word-only register hits.
    always_comb begin
        nbytes     = size_to_bytes(acc_size);
        is_word    = (acc_size == SZ_WORD);
        hit_status = is_word && (acc_addr == STATUS_ADDR);
        hit_app    = is_word && (acc_addr == APP_ADDR);
        wr_any     = acc_valid && acc_write;
        rd_any     = acc_valid && !acc_write;
    end

    shb_prio_store #(
        .ADDR_W (ADDR_W),
        .BASE   (PRIO_BASE),
        .NBYTES (NPRIO),
        .LANES  (LANES)
    ) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_any && !hit_status && !hit_app),
        .addr      (acc_addr),
        .nbytes    (nbytes),
        .wdata     (acc_wdata),
        .rdata     (prio_rdata),
        .prio_flat (prio_bytes)
    );

    shb_status_word u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_any && hit_status),
        .en_wdata   (acc_wdata[18:16]),
        .act_flags  (act_flags),
        .pend_flags (pend_flags),
        .fault_en   (fault_en),
        .rdata      (status_rdata)
    );

    shb_app_ctrl u_app (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_any && hit_app),
        .key_in    (acc_wdata[31:16]),
        .rst_bit   (acc_wdata[2]),
        .rdata     (app_rdata),
        .reset_req (sys_reset_req)
    );

    // Select the read source for the current access.
    always_comb begin
        acc_rdata = '0;
        if (rd_any) begin
            if (hit_status) begin
                acc_rdata = status_rdata;
            end else if (hit_app) begin
                acc_rdata = app_rdata;
            end else begin
                acc_rdata = prio_rdata;
            end
        end
    end

    // R11: a non-word write leaves the fault enables untouched.
    p_word_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && (acc_size != SZ_WORD)) |=> $stable(fault_en))
        else $error("narrow write changed fault enables");

    // R11: a non-word write never raises a reset request.
    p_no_narrow_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && (acc_size != SZ_WORD)) |=> !sys_reset_req)
        else $error("narrow write raised reset request");

endmodule

// File: tb/shb_regbank_bench.sv
module shb_regbank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BASE = 'hD18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [6:0]  act_flags = '0;
    logic [3:0]  pend_flags = '0;
    logic [2:0]  fault_en;
    logic [95:0] prio_bytes;
    logic        sys_reset_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [7:0] mdl [12];

    always #(CLK_PERIOD/2) clk = ~clk;

    shb_regbank u_shb_regbank (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .act_flags(act_flags), .pend_flags(pend_flags),
        .fault_en(fault_en), .prio_bytes(prio_bytes), .sys_reset_req(sys_reset_req)
    );

    task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] szc(input int n);
        return (n == 1) ? 2'd0 : (n == 2) ? 2'd1 : 2'd2;
    endfunction

    task automatic wr(input int a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 12'(a); acc_size = sz; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input int a, input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 12'(a); acc_size = sz;
        #1;
        d = acc_rdata;
        acc_valid = 1'b0;
    endtask

    // Model update for a priority write of n bytes.
    task automatic mdl_wr(input int a, input int n, input logic [31:0] d);
        for (int i = 0; i < n; i++) begin
            int idx = a + i - BASE;
            if (idx >= 0 && idx < 12) mdl[idx] = d[8*i +: 8];
        end
    endtask

    function automatic logic [31:0] mdl_rd(input int a, input int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) begin
            int idx = a + i - BASE;
            if (idx >= 0 && idx < 12) r[8*i +: 8] = mdl[idx];
        end
        return r;
    endfunction

    function automatic logic [95:0] mdl_flat();
        logic [95:0] r;
        for (int k = 0; k < 12; k++) r[8*k +: 8] = mdl[k];
        return r;
    endfunction

    function automatic logic [31:0] exp_status(input logic [6:0] a, input logic [3:0] p, input logic [2:0] e);
        logic [31:0] r = '0;
        r[0] = a[0]; r[1] = a[1]; r[3] = a[2]; r[7] = a[3];
        r[8] = a[4]; r[10] = a[5]; r[11] = a[6];
        r[12] = p[2]; r[13] = p[0]; r[14] = p[1]; r[15] = p[3];
        r[18:16] = e;
        return r;
    endfunction

    // Sweep reads of every size over the region and its edges.
    task automatic sweep_reads(input string tag);
        logic [31:0] d;
        for (int a = BASE - 3; a <= BASE + 12; a++) begin
            for (int s = 0; s < 3; s++) begin
                int n = (s == 0) ? 1 : (s == 1) ? 2 : 4;
                rd(a, szc(n), d);
                chk(tag, 96'(d), 96'(mdl_rd(a, n)));
            end
        end
        chk({tag, " flat R2"}, prio_bytes, mdl_flat());
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [2:0]  en_m;
        for (int k = 0; k < 12; k++) mdl[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 enables", 96'(fault_en), 96'(0));
        chk("R1 reset req", 96'(sys_reset_req), 96'(0));
        sweep_reads("R1 R3 reset reads");

        // R2: byte writes to every priority byte
        for (int k = 0; k < 12; k++) begin
            logic [31:0] v = 32'((k * 37 + 5) & 8'hFF) | 32'hABCDEF00;
            wr(BASE + k, 2'd0, v);
            mdl_wr(BASE + k, 1, v);
        end
        sweep_reads("R2 R3 after byte writes");

        // R2 R3: halfword writes at every offset, including the region edges
        for (int a = BASE - 1; a <= BASE + 11; a++) begin
            logic [31:0] v = 32'(a * 32'h0001_3579);
            wr(a, 2'd1, v);
            mdl_wr(a, 2, v);
        end
        sweep_reads("R2 R3 after halfword writes");

        // R2 R3: word writes at every offset, straddling both ends
        for (int a = BASE - 3; a <= BASE + 11; a++) begin
            if (a == 'hD24) continue;
            begin
                logic [31:0] v = 32'(a * 32'h9E37_79B9);
                wr(a, 2'd2, v);
                mdl_wr(a, 4, v);
            end
        end
        sweep_reads("R2 R3 after word writes");

        // R11: size code 3 writes nothing
        wr(BASE, 2'd3, 32'hFFFF_FFFF);
        chk("R11 size3 flat", prio_bytes, mdl_flat());

        // R4 R5: sweep all active patterns with varied pending patterns
        for (int a = 0; a < 128; a++) begin
            @(negedge clk);
            act_flags = 7'(a);
            pend_flags = 4'(a * 5 + 3);
            rd('hD24, 2'd2, d);
            chk("R4 R5 status flags", 96'(d), 96'(exp_status(7'(a), 4'(a * 5 + 3), 3'b000)));
        end

        // R6 R7: enable writes with every other status bit set
        for (int e = 0; e < 8; e++) begin
            @(negedge clk);
            act_flags = 7'h00; pend_flags = 4'h0;
            wr('hD24, 2'd2, 32'hFFF8_FFFF | (32'(e) << 16));
            chk("R6 fault_en", 96'(fault_en), 96'(e));
            rd('hD24, 2'd2, d);
            chk("R6 R7 readback", 96'(d), 96'(exp_status(7'h00, 4'h0, 3'(e))));
        end
        en_m = 3'b111;

        // Same cycle: flags change while enables are written
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 12'hD24; acc_size = 2'd2;
        acc_wdata = 32'h0002_0000;
        act_flags = 7'h55; pend_flags = 4'hA;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        en_m = 3'b010;
        rd('hD24, 2'd2, d);
        chk("R6 R7 same-cycle", 96'(d), 96'(exp_status(7'h55, 4'hA, en_m)));

        // R11: narrow writes to the status word are ignored
        wr('hD24, 2'd1, 32'hFFFF_FFFF);
        wr('hD26, 2'd0, 32'hFFFF_FFFF);
        wr('hD24, 2'd3, 32'hFFFF_FFFF);
        chk("R11 narrow status", 96'(fault_en), 96'(en_m));

        // R8: fixed read pattern
        rd('hD0C, 2'd2, d);
        chk("R8 app read", 96'(d), 96'(32'hFA05_0000));

        // R9: wrong keys and keyed writes without the reset bit
        wr('hD0C, 2'd2, 32'h05FB_0004);
        chk("R9 wrong key", 96'(sys_reset_req), 96'(0));
        wr('hD0C, 2'd2, 32'hFA05_0004);
        chk("R9 swapped key", 96'(sys_reset_req), 96'(0));
        wr('hD0C, 2'd2, 32'h05FA_0003);
        chk("R9 no reset bit", 96'(sys_reset_req), 96'(0));
        wr('hD0C, 2'd1, 32'h05FA_0004);
        chk("R11 narrow app", 96'(sys_reset_req), 96'(0));

        // R10: keyed write with the reset bit pulses one cycle
        wr('hD0C, 2'd2, 32'h05FA_0004);
        chk("R10 pulse high", 96'(sys_reset_req), 96'(1));
        @(negedge clk);
        chk("R10 pulse low", 96'(sys_reset_req), 96'(0));

        // R10: back-to-back keyed writes never hold the request two cycles
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 12'hD0C; acc_size = 2'd2;
        acc_wdata = 32'h05FA_0004;
        @(negedge clk);
        chk("R10 first of pair", 96'(sys_reset_req), 96'(1));
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        chk("R10 second of pair", 96'(sys_reset_req), 96'(0));

        // R1: reset again clears priorities and enables
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 12; k++) mdl[k] = 8'h00;
        chk("R1 reset flat", prio_bytes, 96'(0));
        chk("R1 reset enables", 96'(fault_en), 96'(0));

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule